// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits on the bus side of a processor core and keeps a short first-in, first-out buffer of upcoming instruction bytes ahead of the execution unit. It holds a 20-bit linear fetch pointer. Whenever the buffer has a free slot, it requests one byte from memory over a request/acknowledge port. Each byte that is acknowledged is stored and the pointer advances by one. The execution side takes bytes through a valid/ready interface.

When the buffer is empty, a byte arriving from memory is presented on the output in the same cycle it arrives. If the consumer takes it, the byte is never written into storage. A taken branch raises the flush input together with the target address. The buffer is then emptied, any acknowledge in that cycle is discarded, and fetching starts again from the target. The address given to the block is already linear, so it does no segment arithmetic.

Top module: `pfq_top`

## Requirements
- R1: After reset the queue is empty, `out_valid_o` is 0, `mem_req_o` is 1 and `mem_addr_o` equals the parameter `RESET_ADDR` (default 00000h).
- R2: `mem_req_o` is 1 in every cycle in which fewer than `DEPTH` (default 4) bytes are stored, and 0 when `DEPTH` bytes are stored.
- R3: No more than `DEPTH` bytes are ever held. A byte accepted in the same cycle as a byte is consumed from a non-empty queue leaves the occupancy unchanged.
- R4: Bytes reach the consumer in exactly the order of the addresses they were fetched from.
- R5: With the queue empty, an accepted memory byte drives `out_valid_o` = 1 and `out_byte_o` = `mem_data_i` in the same cycle.
- R6: The fetch address rises by one for each accepted byte (`mem_req_o` and `mem_ack_i` both 1, `flush_i` 0) and wraps from FFFFFh to 00000h.
- R7: While `mem_req_o` is 1, `mem_ack_i` is 0 and `flush_i` is 0, the next cycle still has `mem_req_o` = 1 and the same `mem_addr_o`.
- R8: A cycle with `flush_i` = 1 empties the queue and ignores any acknowledge in that cycle. The next fetch address is `flush_addr_i`, and the next byte delivered comes from that address.
- R9: While `flush_i` is 1, `out_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Branch taken: empty the queue and redirect fetching |
| flush_addr_i | input | 20 | Linear branch target address |
| mem_req_o | output | 1 | Byte read request |
| mem_addr_o | output | 20 | Byte address being requested |
| mem_ack_i | input | 1 | Memory returns `mem_data_i` for the current request |
| mem_data_i | input | 8 | Returned byte |
| out_valid_o | output | 1 | An instruction byte is offered |
| out_byte_o | output | 8 | Offered instruction byte |
| out_ready_i | input | 1 | Consumer takes the offered byte |

## Verification
The assertions check the following on every cycle: the occupancy limit, the request staying low while the queue is full, the request and address holding steady while a request waits, the one-step pointer advance, the redirect after a flush, and the same-cycle bypass. Only the bench scenarios can show the rest. These are the end-to-end byte order across many acknowledge and ready rhythms, the wrap of the address past FFFFFh, and that an acknowledge arriving together with a flush never shows up on the output.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] ibyte_t;
endpackage

// File: rtl/pfq_rst_sync.sv
module pfq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pfq_fifo.sv
module pfq_fifo
  import pfq_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic wr_en,
  input  ibyte_t wr_data,
  input  logic rd_en,
  output ibyte_t rd_data,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic empty,
  output logic full
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);

  ibyte_t          mem_q [DEPTH];
  logic [PW-1:0]   wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0]   cnt_q, cnt_d;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (wr_en) wptr_d = bump(wptr_q);
      if (rd_en) rptr_d = bump(rptr_q);
      case ({wr_en, rd_en})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && !clr && (wptr_q == PW'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem_q[gi] <= '0;
      else if (slot_en) mem_q[gi] <= wr_data;
    end
  end

  assign rd_data = mem_q[rptr_q];
  assign count   = cnt_q;
  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && full && !rd_en && !clr));
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && empty && !clr));
  p_clr_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch #(
  parameter int unsigned           AW         = 20,
  parameter logic [AW-1:0]         RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [AW-1:0] flush_addr,
  input  logic          room,
  input  logic          ack,
  output logic          req,
  output logic [AW-1:0] addr,
  output logic          accept
);
  logic [AW-1:0] ptr_q, ptr_d;

  assign req    = room;
  assign accept = req && ack && !flush;

  always_comb begin
    ptr_d = ptr_q;
    if (flush)       ptr_d = flush_addr;
    else if (accept) ptr_d = ptr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= RESET_ADDR;
    else        ptr_q <= ptr_d;
  end

  assign addr = ptr_q;

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack && !flush) |=> (req && $stable(addr)));
  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (addr == $past(addr) + AW'(1)));
  p_flush_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (addr == $past(flush_addr)));
endmodule

// File: rtl/pfq_top.sv
module pfq_top
  import pfq_pkg::*;
#(
  parameter int unsigned   AW         = 20,
  parameter int unsigned   DEPTH      = 4,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic [AW-1:0] flush_addr_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_ack_i,
  input  logic [7:0]    mem_data_i,
  output logic          out_valid_o,
  output logic [7:0]    out_byte_o,
  input  logic          out_ready_i
);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic          rst_s_n;
  logic          accept, take;
  logic          q_wr, q_rd, q_empty, q_full;
  ibyte_t        q_head;
  logic [CW-1:0] q_count;

  pfq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  pfq_fetch #(.AW(AW), .RESET_ADDR(RESET_ADDR)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .flush      (flush_i),
    .flush_addr (flush_addr_i),
    .room       (!q_full),
    .ack        (mem_ack_i),
    .req        (mem_req_o),
    .addr       (mem_addr_o),
    .accept     (accept)
  );

  // Bypass: an empty queue shows the arriving byte directly.
  assign out_valid_o = !flush_i && (!q_empty || accept);
  assign out_byte_o  = q_empty ? mem_data_i : q_head;
  assign take        = out_valid_o && out_ready_i;
  assign q_rd        = take && !q_empty;
  assign q_wr        = accept && !(take && q_empty);

  pfq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .clr     (flush_i),
    .wr_en   (q_wr),
    .wr_data (mem_data_i),
    .rd_en   (q_rd),
    .rd_data (q_head),
    .count   (q_count),
    .empty   (q_empty),
    .full    (q_full)
  );

  p_full_no_req_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (q_count == CW'(DEPTH)) |-> !mem_req_o);
  p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (q_empty && accept) |-> (out_valid_o && out_byte_o == mem_data_i));
  p_flush_quiet_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    flush_i |-> !out_valid_o);
endmodule

// File: tb/pfq_top_tb.sv
module pfq_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush;
  logic [19:0] flush_addr;
  logic        mem_req;
  logic [19:0] mem_addr;
  logic        mem_ack;
  logic [7:0]  mem_data;
  logic        out_valid;
  logic [7:0]  out_byte;
  logic        out_ready;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc_n  = 0;

  // Bench model
  int          m_cnt;
  logic [19:0] m_fetch;
  logic [19:0] m_next;

  always #2 clk = ~clk;

  function automatic logic [7:0] mfun(input logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], 4'h5};
  endfunction

  assign mem_data = mfun(mem_addr);

  pfq_top u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (flush),
    .flush_addr_i (flush_addr),
    .mem_req_o    (mem_req),
    .mem_addr_o   (mem_addr),
    .mem_ack_i    (mem_ack),
    .mem_data_i   (mem_data),
    .out_valid_o  (out_valid),
    .out_byte_o   (out_byte),
    .out_ready_i  (out_ready)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc_n);
    end
  endtask

  // One cycle: drive at negedge, check, update model at posedge.
  task automatic step(input logic ack, input logic rdy, input logic fl, input logic [19:0] tgt);
    logic acc, pop;
    mem_ack = ack; out_ready = rdy; flush = fl; flush_addr = tgt;
    #1;
    acc = mem_req && ack && !fl;
    chk(mem_req == (m_cnt < 4), "R2 request vs occupancy", mem_req, (m_cnt < 4));
    chk(mem_addr == m_fetch, "R6/R7 fetch address", mem_addr, m_fetch);
    if (fl)
      chk(!out_valid, "R9 valid during flush", out_valid, 0);
    else
      chk(out_valid == (m_cnt > 0 || acc), "R5 valid/bypass", out_valid, (m_cnt > 0 || acc));
    pop = out_valid && rdy;
    if (pop) begin
      chk(out_byte == mfun(m_next), "R4 byte order", out_byte, mfun(m_next));
      if (m_cnt == 0)
        chk(out_byte == mem_data, "R5 bypass byte", out_byte, mem_data);
    end
    @(posedge clk);
    cyc_n++;
    if (fl) begin
      m_cnt = 0; m_fetch = tgt; m_next = tgt;
    end else begin
      if (acc) m_fetch = m_fetch + 20'd1;
      if (pop) m_next = m_next + 20'd1;
      m_cnt = m_cnt + (acc ? 1 : 0) - ((pop && (m_cnt > 0 || acc)) ? 1 : 0);
      if (m_cnt > 4) chk(1'b0, "R3 occupancy model", m_cnt, 4);
    end
    @(negedge clk);
  endtask

  initial begin : watchdog
    #400000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; flush = 1'b0; flush_addr = '0; mem_ack = 1'b0; out_ready = 1'b0;
    m_cnt = 0; m_fetch = 20'h00000; m_next = 20'h00000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    #1;
    chk(!out_valid, "R1 valid after reset", out_valid, 0);
    chk(mem_req, "R1 request after reset", mem_req, 1);
    chk(mem_addr == 20'h0, "R1 address after reset", mem_addr, 0);
    @(negedge clk);

    // R2/R3: fill with consumer stalled, then hold while full
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b0, '0);
    chk(m_cnt == 4 && !mem_req, "R2 full stops requests", mem_req, 0);
    // R3: push+pop at occupancy 3 keeps the count
    step(1'b0, 1'b1, 1'b0, '0);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b0, '0);
    // drain
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b0, '0);
    chk(!out_valid, "R4 drained queue", out_valid, 0);

    // Near-exhaustive rhythm sweep of acknowledge and ready periods
    for (int ap = 0; ap < 4; ap++)
      for (int rp = 0; rp < 4; rp++)
        for (int c = 0; c < 40; c++)
          step((c % (ap + 1)) == 0, (c % (rp + 1)) == rp, 1'b0, '0);

    // R8: flush with acknowledge in the same cycle, queue partly full
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, '0);
    step(1'b1, 1'b1, 1'b1, 20'h12345);
    chk(!out_valid, "R8 queue empty after flush", out_valid, 0);
    for (int i = 0; i < 12; i++) step(i % 2 == 0, 1'b1, 1'b0, '0);

    // R6 wrap past FFFFFh, R7 stalled request
    step(1'b0, 1'b0, 1'b1, 20'hFFFFD);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, '0);
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b0, '0);
    chk(m_fetch == 20'h00007, "R6 wrap reached", m_fetch, 20'h7);

    // R8: flush while full, then refill and bypass from target
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0, '0);
    step(1'b0, 1'b0, 1'b1, 20'hABCDE);
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b0, '0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule